// File: doc/BRIEF.md
# Device-to-Host Status Frame Receiver

This host-side block watches the stream of decoded incoming frames. Each frame arrives as 32-bit dwords, one per cycle, with start and end markers. It picks out the two frames a device uses to report status. The register frame refreshes the whole shadow taskfile. The set-device-bits frame touches only the Error register and six of the eight Status bits. The block keeps the shadow Status, Error, LBA, device and sector-count registers that host software reads. It holds an interrupt-pending flag that a Status read clears.

Whether an update is applied depends on the current busy (Status bit 7) and data-request (Status bit 3) bits. A register frame that arrives while both bits are clear is dropped. A set-device-bits frame is always applied, but it can raise an interrupt only while both bits are clear. The block rejects any frame whose type is not supported, or whose length does not match its type. It pulses a bad-frame output so the link layer can answer with an error handshake, and it changes nothing. Issuing a command sets the busy bit.

Top module: `d2h_status_rx`

## Requirements
- R1: After reset, status is 80h, error is 00h, lba, device and count are zero, and irq_pend and bad_frame are low.
- R2: A register frame is type 34h in dw0[7:0] and exactly 5 dwords long. If busy or data-request is set when it arrives, the block loads it one cycle after the cycle that holds the end-marked beat. The fields load as follows: status from dw0[23:16], error from dw0[31:24], lba[23:0] from dw1[23:0], device from dw1[31:24], lba[47:24] from dw2[23:0], count from dw3[15:0].
- R3: A register frame that arrives while Status bits 7 and 3 are both clear is dropped. No shadow register and no interrupt flag changes.
- R4: A set-device-bits frame is type A1h and exactly 2 dwords long. It loads error from dw0[31:24], Status bits 6..4 from dw0[22:20] and Status bits 2..0 from dw0[18:16]. Status bits 7 and 3 and the taskfile keep their values.
- R5: The interrupt bit is dw0[14]. In a set-device-bits frame it sets irq_pend only if Status bits 7 and 3 were both clear on arrival. In a register frame it sets irq_pend whenever the frame is applied.
- R6: A high sts_rd clears irq_pend at the next edge. If a frame sets the flag in that same cycle, the flag ends up set.
- R7: A frame with any other type, or with a length that does not match its type, raises bad_frame for one cycle after its end-marked beat. It changes no register.
- R8: A high cmd_start sets Status bit 7 at the next edge.
- R9: A beat with rx_valid low is ignored. A valid beat that arrives outside a frame without a start marker is ignored. A start marker inside a frame abandons the partial frame and begins a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Incoming dword valid |
| rx_sof | input | 1 | First dword of a frame |
| rx_eof | input | 1 | Last dword of a frame |
| rx_data | input | 32 | Incoming dword |
| cmd_start | input | 1 | Command issued; sets busy |
| sts_rd | input | 1 | Host software reads Status |
| status | output | 8 | Shadow Status register |
| error | output | 8 | Shadow Error register |
| lba | output | 48 | Shadow LBA bytes |
| device | output | 8 | Shadow device register |
| count | output | 16 | Shadow sector count |
| irq_pend | output | 1 | Interrupt pending |
| bad_frame | output | 1 | One-cycle pulse for a rejected frame |

## Verification
The bench sends register frames while data-request is set and again while idle, so the test tells a frame that is applied from one that is dropped. It sends set-device-bits frames whose status field has every bit set, to show that busy and data-request stay unchanged. Each interrupt bit is sent both while busy and while idle. The bench also sends wrong types, frames too short and too long for their type, stray unmarked beats, and a frame cut off by a new start marker. It reads Status in the same cycle an interrupt is raised, to check which of the two wins.

// File: rtl/d2h_rx_pkg.sv
package d2h_rx_pkg;
    localparam int DW      = 32;
    localparam int MAX_DW  = 5;
    localparam int CNT_W   = $clog2(MAX_DW + 2);
    localparam int LEN_REG = 5;
    localparam int LEN_SDB = 2;
    localparam int IRQ_BIT = 14;
    localparam int BSY_BIT = 7;
    localparam int DRQ_BIT = 3;

    localparam logic [7:0] TYPE_REG = 8'h34;
    localparam logic [7:0] TYPE_SDB = 8'hA1;
    localparam logic [7:0] STATUS_RST = 8'h80;

    typedef logic [DW-1:0] dword_t;

    typedef enum logic [1:0] {K_NONE, K_REG, K_SDB, K_BAD} kind_e;

    typedef struct packed {
        logic [7:0]  status;
        logic [7:0]  error;
        logic [47:0] lba;
        logic [7:0]  device;
        logic [15:0] count;
    } shadow_t;

    // keep busy and data-request, take the six device-owned bits
    function automatic logic [7:0] merge_bits(input logic [7:0] cur, input logic [7:0] fld);
        return {cur[BSY_BIT], fld[6:4], cur[DRQ_BIT], fld[2:0]};
    endfunction

    function automatic logic is_idle(input logic [7:0] st);
        return !st[BSY_BIT] && !st[DRQ_BIT];
    endfunction
endpackage

// File: rtl/d2h_collect.sv
module d2h_collect
    import d2h_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_valid,
    input  logic             rx_sof,
    input  logic             rx_eof,
    input  dword_t           rx_data,
    output logic             done,
    output logic [CNT_W-1:0] cnt,
    output dword_t           words [MAX_DW]
);
    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(MAX_DW + 1);

    logic in_frame;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_frame <= 1'b0;
            done     <= 1'b0;
            cnt      <= '0;
            for (int i = 0; i < MAX_DW; i++) words[i] <= '0;
        end else begin
            done <= 1'b0;
            if (rx_valid) begin
                if (rx_sof) begin
                    words[0] <= rx_data;
                    cnt      <= CNT_W'(1);
                    in_frame <= !rx_eof;
                    done     <= rx_eof;
                end else if (in_frame) begin
                    for (int i = 1; i < MAX_DW; i++)
                        if (cnt == CNT_W'(i)) words[i] <= rx_data;
                    if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
                    if (rx_eof) begin
                        in_frame <= 1'b0;
                        done     <= 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/d2h_classify.sv
module d2h_classify
    import d2h_rx_pkg::*;
(
    input  logic             done,
    input  logic [CNT_W-1:0] cnt,
    input  dword_t           head,
    output kind_e            kind
);
    logic [7:0] ftype;
    assign ftype = head[7:0];

    always_comb begin
        if (!done)
            kind = K_NONE;
        else if (ftype == TYPE_REG && cnt == CNT_W'(LEN_REG))
            kind = K_REG;
        else if (ftype == TYPE_SDB && cnt == CNT_W'(LEN_SDB))
            kind = K_SDB;
        else
            kind = K_BAD;
    end
endmodule

// File: rtl/d2h_shadow.sv
module d2h_shadow
    import d2h_rx_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  kind_e   kind,
    input  dword_t  words [MAX_DW],
    input  logic    cmd_start,
    input  logic    sts_rd,
    output shadow_t sh,
    output logic    irq
);
    shadow_t nxt;
    logic    irq_set;

    always_comb begin
        nxt     = sh;
        irq_set = 1'b0;
        case (kind)
            K_REG: if (!is_idle(sh.status)) begin
                nxt.status = words[0][23:16];
                nxt.error  = words[0][31:24];
                nxt.lba    = {words[2][23:0], words[1][23:0]};
                nxt.device = words[1][31:24];
                nxt.count  = words[3][15:0];
                irq_set    = words[0][IRQ_BIT];
            end
            K_SDB: begin
                nxt.error  = words[0][31:24];
                nxt.status = merge_bits(sh.status, words[0][23:16]);
                irq_set    = words[0][IRQ_BIT] && is_idle(sh.status);
            end
            default: ;
        endcase
        if (cmd_start) nxt.status[BSY_BIT] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh        <= '0;
            sh.status <= STATUS_RST;
            irq       <= 1'b0;
        end else begin
            sh <= nxt;
            if (irq_set)     irq <= 1'b1;
            else if (sts_rd) irq <= 1'b0;
        end
    end
endmodule

// File: rtl/d2h_status_rx.sv
module d2h_status_rx
    import d2h_rx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        rx_valid,
    input  logic        rx_sof,
    input  logic        rx_eof,
    input  logic [31:0] rx_data,
    input  logic        cmd_start,
    input  logic        sts_rd,
    output logic [7:0]  status,
    output logic [7:0]  error,
    output logic [47:0] lba,
    output logic [7:0]  device,
    output logic [15:0] count,
    output logic        irq_pend,
    output logic        bad_frame
);
    logic             frm_done;
    logic [CNT_W-1:0] frm_cnt;
    dword_t           frm_words [MAX_DW];
    kind_e            frm_kind;
    shadow_t          sh;

    d2h_collect u_collect (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_sof(rx_sof),
        .rx_eof(rx_eof), .rx_data(rx_data), .done(frm_done),
        .cnt(frm_cnt), .words(frm_words)
    );

    d2h_classify u_classify (
        .done(frm_done), .cnt(frm_cnt), .head(frm_words[0]), .kind(frm_kind)
    );

    d2h_shadow u_shadow (
        .clk(clk), .rst(rst), .kind(frm_kind), .words(frm_words),
        .cmd_start(cmd_start), .sts_rd(sts_rd), .sh(sh), .irq(irq_pend)
    );

    assign status    = sh.status;
    assign error     = sh.error;
    assign lba       = sh.lba;
    assign device    = sh.device;
    assign count     = sh.count;
    assign bad_frame = (frm_kind == K_BAD);
endmodule

// File: rtl/d2h_status_rx_chk.sv
module d2h_status_rx_chk
    import d2h_rx_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        cmd_start,
    input logic        sts_rd,
    input logic [7:0]  status,
    input logic [7:0]  error,
    input logic [47:0] lba,
    input logic        irq_pend,
    input kind_e       frm_kind
);
    AST_IDLE_REG_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (frm_kind == K_REG && !status[BSY_BIT] && !status[DRQ_BIT])
        |=> ($stable(error) && $stable(lba)));                          // R3

    AST_SDB_KEEPS_BSY_DRQ: assert property (@(posedge clk) disable iff (rst)
        (frm_kind == K_SDB && !cmd_start)
        |=> (status[BSY_BIT] == $past(status[BSY_BIT]) &&
             status[DRQ_BIT] == $past(status[DRQ_BIT])));               // R4

    AST_IRQ_NEEDS_FRAME: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_pend) |-> ($past(frm_kind) == K_REG || $past(frm_kind) == K_SDB)); // R5

    AST_READ_CLEARS_IRQ: assert property (@(posedge clk) disable iff (rst)
        (sts_rd && frm_kind == K_NONE) |=> !irq_pend);                  // R6

    AST_BAD_CHANGES_NOTHING: assert property (@(posedge clk) disable iff (rst)
        (frm_kind == K_BAD && !cmd_start)
        |=> ($stable(status) && $stable(error) && $stable(lba)));       // R7

    AST_CMD_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
        cmd_start |=> status[BSY_BIT]);                                 // R8
endmodule

bind d2h_status_rx d2h_status_rx_chk u_chk (
    .clk(clk), .rst(rst), .cmd_start(cmd_start), .sts_rd(sts_rd),
    .status(status), .error(error), .lba(lba), .irq_pend(irq_pend),
    .frm_kind(frm_kind)
);

// File: tb/sim_d2h_status_rx.sv
module sim_d2h_status_rx;
    logic        clk = 1'b0;
    logic        rst;
    logic        rx_valid, rx_sof, rx_eof, cmd_start, sts_rd;
    logic [31:0] rx_data;
    logic [7:0]  status, error, device;
    logic [47:0] lba;
    logic [15:0] count;
    logic        irq_pend, bad_frame;

    int n_chk = 0;
    int n_fail = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    d2h_status_rx u0 (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_sof(rx_sof),
        .rx_eof(rx_eof), .rx_data(rx_data), .cmd_start(cmd_start),
        .sts_rd(sts_rd), .status(status), .error(error), .lba(lba),
        .device(device), .count(count), .irq_pend(irq_pend),
        .bad_frame(bad_frame)
    );

    always @(negedge clk) if (!rst && bad_frame) n_bad++;

    typedef struct packed {
        logic [159:0] w;
        logic [2:0]   len;
        logic [7:0]   st;
        logic [7:0]   er;
        logic [47:0]  lb;
        logic [7:0]   dv;
        logic [15:0]  ct;
        logic         irq;
        logic         bad;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        // R2 register frame applied at reset busy
        '{{32'h0, 32'h00000010, 32'h00665544, 32'hA0332211, 32'h00580034}, 3'd5,
          8'h58, 8'h00, 48'h665544332211, 8'hA0, 16'h0010, 1'b0, 1'b0},
        // R2 R5 applied with data-request set, interrupt bit set
        '{{32'h0, 32'h0000ABCD, 32'h00FFEEDD, 32'hE0CCBBAA, 32'h01514034}, 3'd5,
          8'h51, 8'h01, 48'hFFEEDDCCBBAA, 8'hE0, 16'hABCD, 1'b1, 1'b0},
        // R3 idle: dropped
        '{{32'h0, 32'h00001111, 32'h00121212, 32'h55343434, 32'h02D04034}, 3'd5,
          8'h51, 8'h01, 48'hFFEEDDCCBBAA, 8'hE0, 16'hABCD, 1'b0, 1'b0},
        // R4 R5 set-device-bits while idle with interrupt
        '{{32'h0, 32'h0, 32'h0, 32'h0, 32'h045340A1}, 3'd2,
          8'h53, 8'h04, 48'hFFEEDDCCBBAA, 8'hE0, 16'hABCD, 1'b1, 1'b0},
        // R4 all status bits set in field: bits 7 and 3 held
        '{{32'h0, 32'h0, 32'h0, 32'h0, 32'hFFFF00A1}, 3'd2,
          8'h77, 8'hFF, 48'hFFEEDDCCBBAA, 8'hE0, 16'hABCD, 1'b0, 1'b0},
        // R7 unsupported type
        '{{32'h0, 32'h0, 32'h0, 32'h0, 32'h12345627}, 3'd5,
          8'h77, 8'hFF, 48'hFFEEDDCCBBAA, 8'hE0, 16'hABCD, 1'b0, 1'b1},
        // R7 register frame too short
        '{{32'h0, 32'h1, 32'h1, 32'h1, 32'h00D04034}, 3'd4,
          8'h77, 8'hFF, 48'hFFEEDDCCBBAA, 8'hE0, 16'hABCD, 1'b0, 1'b1},
        // R7 set-device-bits too long
        '{{32'h0, 32'h0, 32'h0, 32'h0, 32'h000040A1}, 3'd3,
          8'h77, 8'hFF, 48'hFFEEDDCCBBAA, 8'hE0, 16'hABCD, 1'b0, 1'b1}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic beat(input logic s, input logic e, input logic [31:0] d);
        @(negedge clk);
        rx_valid = 1'b1; rx_sof = s; rx_eof = e; rx_data = d;
    endtask

    task automatic send(input logic [159:0] w, input int len, input logic rd_hold);
        for (int i = 0; i < len; i++) beat(i == 0, i == len - 1, w[32*i +: 32]);
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; sts_rd = rd_hold;
        @(negedge clk);
        sts_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic read_status;
        @(negedge clk); sts_rd = 1'b1;
        @(negedge clk); sts_rd = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual running expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int b0;
        rst = 1'b1; rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
        rx_data = '0; cmd_start = 1'b0; sts_rd = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 status", 64'(status), 64'h80);
        check("R1 error", 64'(error), 64'h0);
        check("R1 lba", 64'(lba), 64'h0);
        check("R1 device/count", 64'({device, count}), 64'h0);
        check("R1 irq", 64'(irq_pend), 64'h0);
        check("R1 bad", 64'(bad_frame), 64'h0);

        for (int i = 0; i < NV; i++) begin
            b0 = n_bad;
            send(VECS[i].w, int'(VECS[i].len), 1'b0);
            check($sformatf("R2/R3/R4 vec%0d status", i), 64'(status), 64'(VECS[i].st));
            check($sformatf("R2/R4 vec%0d error", i), 64'(error), 64'(VECS[i].er));
            check($sformatf("R2 vec%0d lba", i), 64'(lba), 64'(VECS[i].lb));
            check($sformatf("R2 vec%0d dev/cnt", i), 64'({device, count}), 64'({VECS[i].dv, VECS[i].ct}));
            check($sformatf("R5 vec%0d irq", i), 64'(irq_pend), 64'(VECS[i].irq));
            check($sformatf("R7 vec%0d bad pulses", i), 64'(n_bad - b0), 64'(VECS[i].bad));
            read_status;
            check($sformatf("R6 vec%0d irq after read", i), 64'(irq_pend), 64'h0);
        end

        // R8 command sets busy
        @(negedge clk); cmd_start = 1'b1;
        @(negedge clk); cmd_start = 1'b0;
        check("R8 busy set", 64'(status), 64'hF7);

        // R5 set-device-bits interrupt while busy is not raised
        send({128'h0, 32'h000040A1}, 2, 1'b0);
        check("R5 sdb busy status", 64'(status), 64'h80);
        check("R5 sdb busy irq", 64'(irq_pend), 64'h0);

        // R6 read in the same cycle as a raising frame: flag set
        send({128'h0, 32'h00504034}, 5, 1'b1);
        check("R6 set wins", 64'(irq_pend), 64'h1);
        check("R2 zero taskfile", 64'(lba), 64'h0);
        check("R2 status", 64'(status), 64'h50);
        read_status;

        // R9 ignored beats
        b0 = n_bad;
        beat(1'b0, 1'b1, 32'h00000034);
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b1; rx_eof = 1'b1; rx_data = 32'h00000027;
        @(negedge clk);
        rx_sof = 1'b0; rx_eof = 1'b0;
        @(negedge clk); @(negedge clk);
        check("R9 no frame from stray beats", 64'(n_bad - b0), 64'h0);
        check("R9 status kept", 64'(status), 64'h50);

        // R9 start marker restarts a frame
        beat(1'b1, 1'b0, 32'h00804034);
        beat(1'b0, 1'b0, 32'h11111111);
        send({128'h0, 32'h2A0700A1}, 2, 1'b0);
        check("R9 restart status", 64'(status), 64'h07);
        check("R9 restart error", 64'(error), 64'h2A);
        check("R9 restart not bad", 64'(n_bad - b0), 64'h0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule